// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block is the bus-side control of a single-unit SCSI block device acting as a target. It watches the initiator's selection signals and claims the bus when its own ID bit appears on the data lines. It then walks the information phases in order: an optional message byte, the command descriptor, a data transfer in either direction, one status byte and one message byte. After that it releases the bus. It drives the three phase lines and REQ, and moves every byte on a four-step REQ/ACK handshake.

Command bytes are gathered until the length implied by the opcode group is reached. The descriptor is then decoded into a next phase, a byte count and a status value. Data flowing to the initiator is pulled one byte at a time from a stream source. Data flowing from the initiator is pushed to a stream sink. The block address and the opcode are presented to the storage side for the duration of the command.

Top module: `tgt_phase_seq`

## Requirements
- R1: The phase lines {msg, cd, io} read 000 for data out, 001 for data in, 010 for command, 011 for status, 110 for message out and 111 for message in. The combinations 100 and 101 never appear.
- R2: From bus free, a high SEL input moves the sequencer to arbitration. There it claims selection (tgt_bsy_o goes high) only when BSY is low, SEL is high, the initiator drives the data bus and data bit ID_BIT (default 6) is set. With both BSY and SEL low it falls back to bus free.
- R3: After selection with ATN high, exactly one message-out byte is taken before the command phase; with ATN low the first phase is command.
- R4: The descriptor is 10 bytes when byte 0 bits 7:5 are 001 or 010, and 6 bytes for every other group.
- R5: Each byte moves on REQ high, ACK high, REQ low, ACK low. REQ never rises while ACK is high, and the phase lines hold still while REQ is high. bus_data_oe_o is high at every REQ of the phases with io = 1 and low at every REQ of the others.
- R6: Opcode 00h goes straight to status. Opcodes 03h, 12h and 1Ah enter data in with byte 4 as the count. Opcode 15h enters data out with byte 4 as the count.
- R7: Opcode 08h enters data in for byte 4 × 512 bytes. It presents the block address {byte1[4:0], byte2, byte3} on blk_lba_o.
- R8: Opcode 25h returns 8 bytes in data in. Opcodes 28h (data in) and 2Ah (data out) move {byte7, byte8} × 512 bytes and present bytes 2..5 (byte 2 most significant) on blk_lba_o.
- R9: A non-zero unit number (byte 1 bits 7:5) or an opcode outside R6..R8 skips the data phase and yields status 02h. Every other command yields status 00h.
- R10: A command whose count is zero skips its data phase and goes straight to status.
- R11: Each data-in byte is the value of src_data_i and is followed by one src_pop_o pulse. Each data-out byte appears on snk_data_o with one snk_push_o pulse.
- R12: The status byte is followed by one message-in byte of 00h. After that, tgt_bsy_o falls and the phase lines return to 000.
- R13: After reset the target is not busy, REQ and the output enable are low, and the phase lines read 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Initiator SEL (asserted high) |
| bus_bsy_i | input | 1 | BSY driven by other devices (asserted high) |
| bus_atn_i | input | 1 | Initiator ATN (asserted high) |
| bus_ack_i | input | 1 | Initiator ACK (asserted high) |
| bus_drv_i | input | 1 | Initiator is driving the data bus |
| bus_data_i | input | 8 | Data bus as received |
| tgt_bsy_o | output | 1 | Target holds BSY |
| bus_req_o | output | 1 | Target REQ |
| ph_msg_o | output | 1 | Phase line MSG |
| ph_cd_o | output | 1 | Phase line C/D |
| ph_io_o | output | 1 | Phase line I/O |
| bus_data_o | output | 8 | Byte driven by the target |
| bus_data_oe_o | output | 1 | Target drives the data bus |
| src_data_i | input | 8 | Next data-in byte from storage |
| src_pop_o | output | 1 | One data-in byte consumed |
| snk_data_o | output | 8 | Data-out byte to storage |
| snk_push_o | output | 1 | snk_data_o holds a new byte |
| blk_lba_o | output | 32 | Block address of the current command |
| cmd_op_o | output | 8 | Opcode of the current command |

## Verification
Directed commands cover each supported opcode, each with a known count and address. A zero allocation tells the skip to status apart from an empty data phase. A non-zero unit number, an unknown 10-byte opcode and an unknown 6-byte opcode separate rejection from descriptor length. A seeded random run mixes opcodes, counts, unit numbers and ATN. Each command is checked against a bench model for the exact phase at every REQ, the data values, the pop and push counts, the status byte and the block address. Near-miss selections (ID bit clear, BSY high, bus not driven) show that only the full selection condition is claimed.

// File: rtl/tgt_seq_pkg.sv
package tgt_seq_pkg;

  typedef enum logic [2:0] {
    ST_FREE, ST_ARB, ST_MSGO, ST_CMD, ST_DIN, ST_DOUT, ST_STAT, ST_MSGI
  } seq_st_t;

  typedef enum logic [1:0] {HS_IDLE, HS_REQ, HS_REL} hs_st_t;

  localparam logic [2:0] PH_DOUT = 3'b000;
  localparam logic [2:0] PH_DIN  = 3'b001;
  localparam logic [2:0] PH_CMD  = 3'b010;
  localparam logic [2:0] PH_STAT = 3'b011;
  localparam logic [2:0] PH_MSGO = 3'b110;
  localparam logic [2:0] PH_MSGI = 3'b111;

  localparam logic [7:0] STS_GOOD  = 8'h00;
  localparam logic [7:0] STS_CHECK = 8'h02;
  localparam logic [7:0] MSG_DONE  = 8'h00;

  localparam logic [7:0] OP_TUR    = 8'h00;
  localparam logic [7:0] OP_SENSE  = 8'h03;
  localparam logic [7:0] OP_RD6    = 8'h08;
  localparam logic [7:0] OP_INQ    = 8'h12;
  localparam logic [7:0] OP_MSEL   = 8'h15;
  localparam logic [7:0] OP_MSENSE = 8'h1A;
  localparam logic [7:0] OP_RDCAP  = 8'h25;
  localparam logic [7:0] OP_RD10   = 8'h28;
  localparam logic [7:0] OP_WR10   = 8'h2A;

  localparam int CAP_BYTES = 8;

  function automatic logic [2:0] phase_of(seq_st_t s);
    case (s)
      ST_DIN:  return PH_DIN;
      ST_CMD:  return PH_CMD;
      ST_STAT: return PH_STAT;
      ST_MSGO: return PH_MSGO;
      ST_MSGI: return PH_MSGI;
      default: return PH_DOUT;
    endcase
  endfunction

endpackage

// File: rtl/tgt_req_ack.sv
module tgt_req_ack
  import tgt_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack,
  output logic req,
  output logic xfer,
  output logic done
);

  hs_st_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= HS_IDLE;
    end else begin
      case (st_q)
        HS_IDLE: if (en)   st_q <= HS_REQ;
        HS_REQ:  if (ack)  st_q <= HS_REL;
        HS_REL:  if (!ack) st_q <= HS_IDLE;
        default:           st_q <= HS_IDLE;
      endcase
    end
  end

  // REQ comes straight from the state register; the byte moves when ACK
  // is seen during REQ and the slot closes when ACK is released.
  assign req  = (st_q == HS_REQ);
  assign xfer = (st_q == HS_REQ) && ack;
  assign done = (st_q == HS_REL) && !ack;

endmodule

// File: rtl/tgt_cdb_collect.sv
module tgt_cdb_collect #(
  parameter int LEN_SHORT = 6,
  parameter int LEN_LONG  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       wr,
  input  logic [7:0] din,
  output logic [7:0] cdb_o [LEN_LONG],
  output logic       full_o
);

  localparam int IDX_W = $clog2(LEN_LONG + 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] need;
  logic [2:0]       grp;

  assign grp = cdb_o[0][7:5];

  always_comb begin
    if (grp == 3'b001 || grp == 3'b010) need = IDX_W'(LEN_LONG);
    else                                need = IDX_W'(LEN_SHORT);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                            idx_q <= '0;
    else if (wr && idx_q < IDX_W'(LEN_LONG))   idx_q <= idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LEN_LONG; i++) cdb_o[i] <= '0;
    end else if (wr) begin
      for (int i = 0; i < LEN_LONG; i++)
        if (idx_q == IDX_W'(i)) cdb_o[i] <= din;
    end
  end

  assign full_o = (idx_q != '0) && (idx_q == need);

endmodule

// File: rtl/tgt_cmd_decode.sv
module tgt_cmd_decode
  import tgt_seq_pkg::*;
#(
  parameter int CDB_LEN   = 10,
  parameter int CNT_W     = 25,
  parameter int BLK_SHIFT = 9,
  parameter int LBA_W     = 32
) (
  input  logic [7:0]       cdb_i [CDB_LEN],
  output seq_st_t          nxt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       sts_o,
  output logic [LBA_W-1:0] lba_o
);

  logic unused_bytes;
  assign unused_bytes = ^{cdb_i[6], cdb_i[9]};

  always_comb begin
    nxt_o = ST_STAT;
    cnt_o = '0;
    sts_o = STS_GOOD;
    lba_o = '0;
    case (cdb_i[0])
      OP_TUR: ;
      OP_SENSE, OP_INQ, OP_MSENSE: begin
        nxt_o = ST_DIN;
        cnt_o = CNT_W'(cdb_i[4]);
      end
      OP_MSEL: begin
        nxt_o = ST_DOUT;
        cnt_o = CNT_W'(cdb_i[4]);
      end
      OP_RD6: begin
        nxt_o = ST_DIN;
        cnt_o = CNT_W'(cdb_i[4]) << BLK_SHIFT;
        lba_o = LBA_W'({cdb_i[1][4:0], cdb_i[2], cdb_i[3]});
      end
      OP_RDCAP: begin
        nxt_o = ST_DIN;
        cnt_o = CNT_W'(CAP_BYTES);
      end
      OP_RD10, OP_WR10: begin
        nxt_o = (cdb_i[0] == OP_WR10) ? ST_DOUT : ST_DIN;
        cnt_o = CNT_W'({cdb_i[7], cdb_i[8]}) << BLK_SHIFT;
        lba_o = LBA_W'({cdb_i[2], cdb_i[3], cdb_i[4], cdb_i[5]});
      end
      default: sts_o = STS_CHECK;
    endcase
    if (cdb_i[1][7:5] != 3'b000) begin
      nxt_o = ST_STAT;
      cnt_o = '0;
      sts_o = STS_CHECK;
    end
    if (cnt_o == '0) nxt_o = ST_STAT;
  end

endmodule

// File: rtl/tgt_phase_seq.sv
module tgt_phase_seq
  import tgt_seq_pkg::*;
#(
  parameter int ID_BIT    = 6,
  parameter int CNT_W     = 25,
  parameter int BLK_SHIFT = 9,
  parameter int LBA_W     = 32,
  parameter int LEN_SHORT = 6,
  parameter int LEN_LONG  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel_i,
  input  logic             bus_bsy_i,
  input  logic             bus_atn_i,
  input  logic             bus_ack_i,
  input  logic             bus_drv_i,
  input  logic [7:0]       bus_data_i,
  output logic             tgt_bsy_o,
  output logic             bus_req_o,
  output logic             ph_msg_o,
  output logic             ph_cd_o,
  output logic             ph_io_o,
  output logic [7:0]       bus_data_o,
  output logic             bus_data_oe_o,
  input  logic [7:0]       src_data_i,
  output logic             src_pop_o,
  output logic [7:0]       snk_data_o,
  output logic             snk_push_o,
  output logic [LBA_W-1:0] blk_lba_o,
  output logic [7:0]       cmd_op_o
);

  seq_st_t          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sts_q;
  logic             hs_en, hs_xfer, hs_done;
  logic [7:0]       cdb [LEN_LONG];
  logic             cdb_full;
  seq_st_t          dec_nxt;
  logic [CNT_W-1:0] dec_cnt;
  logic [7:0]       dec_sts;
  logic [LBA_W-1:0] dec_lba;
  logic             sel_hit;

  assign hs_en = (st_q != ST_FREE) && (st_q != ST_ARB);

  tgt_req_ack u_hs (
    .clk  (clk),
    .rst  (rst),
    .en   (hs_en),
    .ack  (bus_ack_i),
    .req  (bus_req_o),
    .xfer (hs_xfer),
    .done (hs_done)
  );

  tgt_cdb_collect #(
    .LEN_SHORT (LEN_SHORT),
    .LEN_LONG  (LEN_LONG)
  ) u_cdb (
    .clk    (clk),
    .rst    (rst),
    .clr    (st_q != ST_CMD),
    .wr     (hs_xfer && st_q == ST_CMD),
    .din    (bus_data_i),
    .cdb_o  (cdb),
    .full_o (cdb_full)
  );

  tgt_cmd_decode #(
    .CDB_LEN   (LEN_LONG),
    .CNT_W     (CNT_W),
    .BLK_SHIFT (BLK_SHIFT),
    .LBA_W     (LBA_W)
  ) u_dec (
    .cdb_i (cdb),
    .nxt_o (dec_nxt),
    .cnt_o (dec_cnt),
    .sts_o (dec_sts),
    .lba_o (dec_lba)
  );

  assign sel_hit = !bus_bsy_i && bus_sel_i && bus_drv_i && bus_data_i[ID_BIT];

  // Phase state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_FREE;
      tgt_bsy_o  <= 1'b0;
      cnt_q      <= '0;
      sts_q      <= STS_GOOD;
      blk_lba_o  <= '0;
      cmd_op_o   <= '0;
      src_pop_o  <= 1'b0;
      snk_push_o <= 1'b0;
      snk_data_o <= '0;
    end else begin
      src_pop_o  <= 1'b0;
      snk_push_o <= 1'b0;
      case (st_q)
        ST_FREE: if (bus_sel_i) st_q <= ST_ARB;
        ST_ARB: begin
          if (sel_hit) begin
            tgt_bsy_o <= 1'b1;
            st_q      <= bus_atn_i ? ST_MSGO : ST_CMD;
          end else if (!bus_bsy_i && !bus_sel_i) begin
            st_q <= ST_FREE;
          end
        end
        ST_MSGO: if (hs_done) st_q <= ST_CMD;
        ST_CMD: begin
          if (hs_done && cdb_full) begin
            st_q      <= dec_nxt;
            cnt_q     <= dec_cnt;
            sts_q     <= dec_sts;
            blk_lba_o <= dec_lba;
            cmd_op_o  <= cdb[0];
          end
        end
        ST_DIN: begin
          if (hs_xfer) begin
            cnt_q     <= cnt_q - 1'b1;
            src_pop_o <= 1'b1;
          end
          if (hs_done && cnt_q == '0) st_q <= ST_STAT;
        end
        ST_DOUT: begin
          if (hs_xfer) begin
            cnt_q      <= cnt_q - 1'b1;
            snk_push_o <= 1'b1;
            snk_data_o <= bus_data_i;
          end
          if (hs_done && cnt_q == '0) st_q <= ST_STAT;
        end
        ST_STAT: if (hs_done) st_q <= ST_MSGI;
        ST_MSGI: begin
          if (hs_done) begin
            st_q      <= ST_FREE;
            tgt_bsy_o <= 1'b0;
          end
        end
        default: st_q <= ST_FREE;
      endcase
    end
  end

  // Byte driven toward the initiator, registered alongside REQ
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data_o    <= '0;
      bus_data_oe_o <= 1'b0;
    end else begin
      case (st_q)
        ST_DIN:  bus_data_o <= src_data_i;
        ST_STAT: bus_data_o <= sts_q;
        ST_MSGI: bus_data_o <= MSG_DONE;
        default: bus_data_o <= '0;
      endcase
      bus_data_oe_o <= (st_q == ST_DIN) || (st_q == ST_STAT) || (st_q == ST_MSGI);
    end
  end

  assign {ph_msg_o, ph_cd_o, ph_io_o} = phase_of(st_q);

endmodule

// File: rtl/tgt_phase_seq_chk.sv
module tgt_phase_seq_chk (
  input logic clk,
  input logic rst,
  input logic tgt_bsy_o,
  input logic bus_req_o,
  input logic bus_ack_i,
  input logic ph_msg_o,
  input logic ph_cd_o,
  input logic ph_io_o,
  input logic src_pop_o,
  input logic snk_push_o
);

  logic [2:0] ph;
  assign ph = {ph_msg_o, ph_cd_o, ph_io_o};

  a_r1_legal_phase: assert property (@(posedge clk) disable iff (rst)
    !(ph_msg_o && !ph_cd_o));

  a_r12_idle_when_free: assert property (@(posedge clk) disable iff (rst)
    !tgt_bsy_o |-> (ph == 3'b000) && !bus_req_o);

  a_r5_req_after_release: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_o) |-> !$past(bus_ack_i));

  a_r5_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && $past(bus_req_o)) |-> $stable(ph));

  a_r11_pop_in_data_in: assert property (@(posedge clk) disable iff (rst)
    src_pop_o |-> (ph == 3'b001) && tgt_bsy_o);

  a_r11_push_in_data_out: assert property (@(posedge clk) disable iff (rst)
    snk_push_o |-> (ph == 3'b000) && tgt_bsy_o);

endmodule

bind tgt_phase_seq tgt_phase_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tgt_bsy_o  (tgt_bsy_o),
  .bus_req_o  (bus_req_o),
  .bus_ack_i  (bus_ack_i),
  .ph_msg_o   (ph_msg_o),
  .ph_cd_o    (ph_cd_o),
  .ph_io_o    (ph_io_o),
  .src_pop_o  (src_pop_o),
  .snk_push_o (snk_push_o)
);

// File: tb/tgt_phase_seq_test.sv
module tgt_phase_seq_test;

  typedef logic [7:0] cdb_t [10];

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        bus_sel_i = 0, bus_bsy_i = 0, bus_atn_i = 0, bus_ack_i = 0, bus_drv_i = 0;
  logic [7:0]  bus_data_i = 8'h00;
  logic        tgt_bsy_o, bus_req_o, ph_msg_o, ph_cd_o, ph_io_o, bus_data_oe_o;
  logic [7:0]  bus_data_o, src_data_i, snk_data_o, cmd_op_o;
  logic        src_pop_o, snk_push_o;
  logic [31:0] blk_lba_o;

  tgt_phase_seq uut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int pop_cnt = 0, push_cnt = 0, push_bad = 0, hs_bad = 0;

  function automatic logic [7:0] src_pat(int k);
    return 8'(k * 37 + 11);
  endfunction
  function automatic logic [7:0] out_pat(int k);
    return 8'(k * 13 + 5);
  endfunction

  assign src_data_i = src_pat(pop_cnt);

  always @(negedge clk) begin
    if (!rst && src_pop_o) pop_cnt++;
    if (!rst && snk_push_o) begin
      if (snk_data_o !== out_pat(push_cnt)) push_bad++;
      push_cnt++;
    end
  end

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ph();
    return {ph_msg_o, ph_cd_o, ph_io_o};
  endfunction

  // One four-step handshake as the initiator
  task automatic xfer_byte(input logic [7:0] wv, output logic [2:0] p, output logic [7:0] rv);
    while (!bus_req_o) @(negedge clk);
    p  = ph();
    rv = bus_data_o;
    if (bus_data_oe_o !== p[0]) hs_bad++;
    bus_data_i = wv;
    bus_ack_i  = 1'b1;
    @(negedge clk);
    while (bus_req_o) @(negedge clk);
    @(negedge clk);
    if (bus_req_o) hs_bad++;
    bus_ack_i = 1'b0;
    @(negedge clk);
  endtask

  // Expected behaviour from the requirements
  task automatic model(input cdb_t c, output int len, output int kind, output int cnt,
                       output logic [7:0] sts, output logic [31:0] lba, output bit lchk,
                       output string tag);
    len  = (c[0][7:5] == 3'd1 || c[0][7:5] == 3'd2) ? 10 : 6;
    kind = 0; cnt = 0; sts = 8'h00; lba = '0; lchk = 0; tag = "R6";
    case (c[0])
      8'h00: ;
      8'h03, 8'h12, 8'h1A: begin kind = 1; cnt = c[4]; end
      8'h15: begin kind = 2; cnt = c[4]; end
      8'h08: begin kind = 1; cnt = c[4] * 512; lba = {11'b0, c[1][4:0], c[2], c[3]}; lchk = 1; tag = "R7"; end
      8'h25: begin kind = 1; cnt = 8; tag = "R8"; end
      8'h28: begin kind = 1; cnt = {c[7], c[8]} * 512; lba = {c[2], c[3], c[4], c[5]}; lchk = 1; tag = "R8"; end
      8'h2A: begin kind = 2; cnt = {c[7], c[8]} * 512; lba = {c[2], c[3], c[4], c[5]}; lchk = 1; tag = "R8"; end
      default: begin sts = 8'h02; tag = "R9"; end
    endcase
    if (c[1][7:5] != 3'b000) begin kind = 0; cnt = 0; sts = 8'h02; lchk = 0; tag = "R9"; end
    if (cnt == 0 && kind != 0) begin kind = 0; tag = "R10"; end
  endtask

  task automatic run_cmd(input cdb_t c, input bit atn);
    int len, kind, cnt, bad, pop0;
    logic [7:0] sts, rv;
    logic [31:0] lba;
    logic [2:0] p;
    bit lchk;
    string tag;
    model(c, len, kind, cnt, sts, lba, lchk, tag);
    pop0 = pop_cnt; push_cnt = 0; push_bad = 0; hs_bad = 0;
    @(negedge clk);
    bus_sel_i = 1; bus_drv_i = 1; bus_data_i = 8'h41; bus_atn_i = atn;
    for (int i = 0; i < 10 && !tgt_bsy_o; i++) @(negedge clk);
    chk(tgt_bsy_o === 1'b1, "R2", "selection claimed", tgt_bsy_o, 1);
    bus_sel_i = 0; bus_drv_i = 0; bus_data_i = 8'h00;
    if (atn) begin
      xfer_byte(8'h80, p, rv);
      chk(p === 3'b110, "R3", "message out phase", p, 3'b110);
      bus_atn_i = 0;
    end
    bad = 0;
    for (int i = 0; i < len; i++) begin
      xfer_byte(c[i], p, rv);
      if (i == 0) chk(p === 3'b010, "R3", "first byte in command phase", p, 3'b010);
      if (p !== 3'b010) bad++;
    end
    chk(bad == 0, "R4", "command phase over descriptor length", bad, 0);
    bad = 0;
    for (int k = 0; k < cnt && kind != 0; k++) begin
      xfer_byte(out_pat(k), p, rv);
      if (p !== ((kind == 1) ? 3'b001 : 3'b000)) bad++;
      if (kind == 1 && rv !== src_pat(pop0 + k)) bad++;
    end
    chk(bad == 0, tag, "data phase bytes and phase", bad, 0);
    xfer_byte(8'h00, p, rv);
    chk(p === 3'b011, (kind == 0) ? tag : "R10", "status phase after data", p, 3'b011);
    chk(rv === sts, "R9", "status byte", rv, sts);
    xfer_byte(8'h00, p, rv);
    chk(p === 3'b111 && rv === 8'h00, "R12", "message in phase/byte", {p, rv}, {3'b111, 8'h00});
    repeat (3) @(negedge clk);
    chk(!tgt_bsy_o && ph() === 3'b000, "R12", "bus released", {tgt_bsy_o, ph()}, 0);
    chk(pop_cnt - pop0 == ((kind == 1) ? cnt : 0), "R11", "source pops", pop_cnt - pop0, (kind == 1) ? cnt : 0);
    chk(push_cnt == ((kind == 2) ? cnt : 0) && push_bad == 0, "R11", "sink pushes", push_cnt, (kind == 2) ? cnt : 0);
    if (lchk) chk(blk_lba_o === lba, tag, "block address", blk_lba_o, lba);
    chk(hs_bad == 0, "R5", "handshake order and output enable", hs_bad, 0);
  endtask

  function automatic cdb_t mk(logic [7:0] op, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3,
                              logic [7:0] b4, logic [7:0] b5, logic [7:0] b7, logic [7:0] b8);
    cdb_t c;
    c = '{default: 8'h00};
    c[0] = op; c[1] = b1; c[2] = b2; c[3] = b3; c[4] = b4; c[5] = b5; c[7] = b7; c[8] = b8;
    return c;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [10];
    ops = '{8'h00, 8'h03, 8'h12, 8'h1A, 8'h15, 8'h08, 8'h25, 8'h28, 8'h2A, 8'h3F};
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk(!tgt_bsy_o && !bus_req_o && !bus_data_oe_o && ph() === 3'b000, "R13", "reset outputs",
        {tgt_bsy_o, bus_req_o, bus_data_oe_o, ph()}, 0);
    // R2 near misses
    bus_sel_i = 1; bus_drv_i = 1; bus_data_i = 8'h01;
    repeat (6) @(negedge clk);
    chk(!tgt_bsy_o, "R2", "ID bit clear not claimed", tgt_bsy_o, 0);
    bus_data_i = 8'h41; bus_bsy_i = 1;
    repeat (6) @(negedge clk);
    chk(!tgt_bsy_o, "R2", "BSY high not claimed", tgt_bsy_o, 0);
    bus_bsy_i = 0; bus_drv_i = 0;
    repeat (6) @(negedge clk);
    chk(!tgt_bsy_o, "R2", "undriven bus not claimed", tgt_bsy_o, 0);
    bus_sel_i = 0; bus_data_i = 8'h00;
    repeat (4) @(negedge clk);
    // Directed commands
    run_cmd(mk(8'h00, 8'h00, 0, 0, 0, 0, 0, 0), 1'b0);
    run_cmd(mk(8'h12, 8'h00, 0, 0, 8'd30, 0, 0, 0), 1'b1);
    run_cmd(mk(8'h12, 8'h00, 0, 0, 8'd0, 0, 0, 0), 1'b0);
    run_cmd(mk(8'h12, 8'h20, 0, 0, 8'd30, 0, 0, 0), 1'b0);
    run_cmd(mk(8'h03, 8'h00, 0, 0, 8'd18, 0, 0, 0), 1'b0);
    run_cmd(mk(8'h1A, 8'h00, 0, 0, 8'd12, 0, 0, 0), 1'b1);
    run_cmd(mk(8'h15, 8'h00, 0, 0, 8'd12, 0, 0, 0), 1'b0);
    run_cmd(mk(8'h25, 8'h00, 0, 0, 0, 0, 0, 0), 1'b0);
    run_cmd(mk(8'h08, 8'h1B, 8'hC4, 8'h5E, 8'd1, 0, 0, 0), 1'b0);
    run_cmd(mk(8'h28, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 8'h02), 1'b1);
    run_cmd(mk(8'h2A, 8'h00, 8'hA0, 8'h0B, 8'hC0, 8'h0D, 8'h00, 8'h01), 1'b0);
    run_cmd(mk(8'h28, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h00, 8'h00), 1'b0);
    run_cmd(mk(8'h3F, 8'h00, 0, 0, 8'd5, 0, 0, 0), 1'b0);
    run_cmd(mk(8'hC5, 8'h00, 0, 0, 8'd5, 0, 0, 0), 1'b0);
    run_cmd(mk(8'h2A, 8'hE0, 0, 0, 0, 0, 8'h00, 8'h01), 1'b0);
    // Seeded random mix
    for (int n = 0; n < 25; n++) begin
      cdb_t c;
      logic [2:0] lun;
      c = '{default: 8'h00};
      for (int i = 0; i < 10; i++) c[i] = 8'($urandom);
      c[0] = ops[$urandom % 10];
      lun = ($urandom % 6 == 0) ? 3'(1 + $urandom % 7) : 3'b000;
      c[1] = {lun, c[1][4:0]};
      c[4] = (c[0] == 8'h08) ? 8'($urandom % 2) : 8'($urandom % 40);
      c[7] = 8'h00;
      c[8] = 8'($urandom % 2);
      run_cmd(c, 1'($urandom));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule